// File: doc/BRIEF.md
# Real-Time Counter and Periodic Interval Timer

This block keeps time for a small system in two independent parts. The first is a free-running counter, 40 bits wide by default, that advances once per pulse of a 32.768 kHz tick enable. Because it counts at that rate, the count from bit 15 upward is elapsed seconds. Software reads it through two words: the low 32 bits and the upper 8 bits. A 40-bit alarm compare value and a rollover detector both raise sticky status flags. The second part is a reloadable down-counter that runs on a faster timer tick enable. It raises a periodic flag once every reload+1 ticks, so software programs it with (tick rate / wanted rate) − 1.

A single control word holds the periodic run and hold bits, separate hold bits for the low and high parts of the counter, and a clear bit. Writing an all-zero word to the control register returns the whole block to idle. Status flags are read from one register and cleared by writing ones to them. The same flags also drive a three-bit interrupt output.

Top module: `tmr_rtc_pit`

## Requirements
- R1: After reset every register reads zero and `irq_stat` is 0.
- R2: Word offsets on `bus_addr` are 0 control, 1 count low, 2 count high, 3 alarm low, 4 alarm high, 5 reload value, 6 status. Each cycle with `rtc_tick` high advances the full count by one. `tmr_tick` has no effect on the count.
- R3: A read of offset 1 copies the current high part into a shadow. Offset 2 returns that shadow, so a high read that follows a low read matches the low read even if the counter has carried since.
- R4: Control bit 2 (low hold) stops the whole count. Control bit 3 (high hold) stops only the high part, so the low part wraps with no carry.
- R5: While control bit 4 (clear) is set the count is zero and stays stopped. Counting resumes from zero once the bit is cleared.
- R6: When the count advances to a value equal to the 40-bit alarm value, status bit 30 sets.
- R7: Status bits are 31 rollover, 30 alarm and 29 periodic. They are sticky until written with one at offset 6. `irq_stat` is {bit31, bit30, bit29}.
- R8: When the full count wraps from all ones to zero, status bit 31 sets.
- R9: With control bit 0 (run) set, the periodic flag (bit 29) sets once every reload+1 timer ticks, and the down-counter reloads on the tick that finds it at zero.
- R10: Control bit 1 (hold) pauses the down-counter without resetting it. Counting resumes from the held value.
- R11: While run is clear the down-counter is held at the reload value and no periodic flag is raised.
- R12: Writing an all-zero word to offset 0 clears every status flag and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rtc_tick | input | 1 | 32.768 kHz count enable, one cycle wide |
| tmr_tick | input | 1 | Timer-rate enable for the down-counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq_stat | output | 3 | Sticky flags {rollover, alarm, periodic} |

## Verification
The hardest state to reach is the full-count wrap: there is no way to load the counter, so at 40 bits it would need 2^40 ticks. The bench shrinks the counter widths through parameters to a 12-bit count. It then drives 4096 tick pulses, which also crosses the alarm match and many low-word carries on the way. The shadow case is reached by reading the low word, ticking across a carry, and only then reading the high word. The hold cases are placed mid-period so that a counter that reloads when resumed gives a visibly different firing tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // control word, bit 4 down to bit 0
    typedef struct packed {
        logic rtc_clr;
        logic frz_hi;
        logic frz_lo;
        logic per_hold;
        logic per_run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_CNT_LO = 3'd1,
        A_CNT_HI = 3'd2,
        A_ALM_LO = 3'd3,
        A_ALM_HI = 3'd4,
        A_PERIOD = 3'd5,
        A_STAT   = 3'd6
    } reg_addr_e;

    localparam int ST_ROLL = 31;
    localparam int ST_ALM  = 30;
    localparam int ST_PER  = 29;

endpackage

// File: rtl/tmr_rtc_core.sv
module tmr_rtc_core #(
    parameter int LO_W = 32,
    parameter int HI_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_ni,
    input  logic                 tick,
    input  logic                 clr,
    input  logic                 frz_lo,
    input  logic                 frz_hi,
    input  logic [LO_W+HI_W-1:0] alarm,
    output logic [LO_W-1:0]      cnt_lo,
    output logic [HI_W-1:0]      cnt_hi,
    output logic                 wrap_p,
    output logic                 alarm_p
);
    typedef struct packed {
        logic [HI_W-1:0] hi;
        logic [LO_W-1:0] lo;
    } rtc_st_t;

    rtc_st_t st_d, st_q;
    logic    adv;

    always_comb begin
        st_d   = st_q;
        adv    = 1'b0;
        wrap_p = 1'b0;
        if (clr) begin
            st_d.lo = '0;
            st_d.hi = '0;
        end else if (tick && !frz_lo) begin
            adv     = 1'b1;
            st_d.lo = st_q.lo + 1'b1;
            if ((&st_q.lo) && !frz_hi) begin
                st_d.hi = st_q.hi + 1'b1;
                wrap_p  = &st_q.hi;
            end
        end
        alarm_p = adv && ({st_d.hi, st_d.lo} == alarm);
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_lo = st_q.lo;
    assign cnt_hi = st_q.hi;

endmodule

// File: rtl/tmr_pit_core.sv
module tmr_pit_core #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic             tick,
    input  logic             run,
    input  logic             hold,
    input  logic [PER_W-1:0] reload,
    output logic [PER_W-1:0] cnt,
    output logic             fire_p
);
    logic [PER_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        fire_p = 1'b0;
        if (!run) begin
            cnt_d = reload;
        end else if (tick && !hold) begin
            if (cnt_q == '0) begin
                cnt_d  = reload;
                fire_p = 1'b1;
            end else begin
                cnt_d = cnt_q - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/tmr_rtc_pit.sv
module tmr_rtc_pit
    import tmr_pkg::*;
#(
    parameter int LO_W  = 32,
    parameter int HI_W  = 8,
    parameter int PER_W = 16
) (
    input  logic        clk,
    input  logic        rst_ni,
    input  logic        rtc_tick,
    input  logic        tmr_tick,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [2:0]  irq_stat
);
    localparam int CW = LO_W + HI_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [LO_W-1:0]  alm_lo;
        logic [HI_W-1:0]  alm_hi;
        logic [PER_W-1:0] period;
        logic [HI_W-1:0]  shadow;
        logic             st_roll;
        logic             st_alm;
        logic             st_per;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [LO_W-1:0]  cnt_lo;
    logic [HI_W-1:0]  cnt_hi;
    logic [PER_W-1:0] pit_cnt;
    logic [CW-1:0]    alarm;
    logic             wrap_p, alarm_p, fire_p;
    logic             rtc_clr, frz_lo, frz_hi, per_run, per_hold;

    assign alarm    = {regs_q.alm_hi, regs_q.alm_lo};
    assign rtc_clr  = regs_q.ctrl.rtc_clr;
    assign frz_lo   = regs_q.ctrl.frz_lo;
    assign frz_hi   = regs_q.ctrl.frz_hi;
    assign per_run  = regs_q.ctrl.per_run;
    assign per_hold = regs_q.ctrl.per_hold;

    tmr_rtc_core #(.LO_W(LO_W), .HI_W(HI_W)) rtc_i (
        .clk     (clk),
        .rst_ni  (rst_ni),
        .tick    (rtc_tick),
        .clr     (rtc_clr),
        .frz_lo  (frz_lo),
        .frz_hi  (frz_hi),
        .alarm   (alarm),
        .cnt_lo  (cnt_lo),
        .cnt_hi  (cnt_hi),
        .wrap_p  (wrap_p),
        .alarm_p (alarm_p)
    );

    tmr_pit_core #(.PER_W(PER_W)) pit_i (
        .clk    (clk),
        .rst_ni (rst_ni),
        .tick   (tmr_tick),
        .run    (per_run),
        .hold   (per_hold),
        .reload (regs_q.period),
        .cnt    (pit_cnt),
        .fire_p (fire_p)
    );

    // next-state for the register file and status flags
    always_comb begin
        regs_d = regs_q;
        if (bus_wr) begin
            case (bus_addr)
                A_CTRL: begin
                    regs_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                    if (bus_wdata == '0) begin
                        regs_d.st_roll = 1'b0;
                        regs_d.st_alm  = 1'b0;
                        regs_d.st_per  = 1'b0;
                    end
                end
                A_ALM_LO: regs_d.alm_lo = bus_wdata[LO_W-1:0];
                A_ALM_HI: regs_d.alm_hi = bus_wdata[HI_W-1:0];
                A_PERIOD: regs_d.period = bus_wdata[PER_W-1:0];
                A_STAT: begin
                    if (bus_wdata[ST_ROLL]) regs_d.st_roll = 1'b0;
                    if (bus_wdata[ST_ALM])  regs_d.st_alm  = 1'b0;
                    if (bus_wdata[ST_PER])  regs_d.st_per  = 1'b0;
                end
                default: ;
            endcase
        end
        if (bus_rd && (bus_addr == A_CNT_LO)) begin
            regs_d.shadow = cnt_hi;
        end
        if (wrap_p)  regs_d.st_roll = 1'b1;
        if (alarm_p) regs_d.st_alm  = 1'b1;
        if (fire_p)  regs_d.st_per  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = 32'(regs_q.ctrl);
            A_CNT_LO: bus_rdata = 32'(cnt_lo);
            A_CNT_HI: bus_rdata = 32'(regs_q.shadow);
            A_ALM_LO: bus_rdata = 32'(regs_q.alm_lo);
            A_ALM_HI: bus_rdata = 32'(regs_q.alm_hi);
            A_PERIOD: bus_rdata = 32'(regs_q.period);
            A_STAT: begin
                bus_rdata[ST_ROLL] = regs_q.st_roll;
                bus_rdata[ST_ALM]  = regs_q.st_alm;
                bus_rdata[ST_PER]  = regs_q.st_per;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq_stat = {regs_q.st_roll, regs_q.st_alm, regs_q.st_per};

endmodule

// File: rtl/tmr_rtc_pit_chk.sv
module tmr_rtc_pit_chk #(
    parameter int LO_W  = 32,
    parameter int HI_W  = 8,
    parameter int PER_W = 16
) (
    input logic                 clk,
    input logic                 rst_ni,
    input logic                 tmr_tick,
    input logic                 rtc_clr,
    input logic                 frz_lo,
    input logic                 per_run,
    input logic                 per_hold,
    input logic [LO_W-1:0]      cnt_lo,
    input logic [HI_W-1:0]      cnt_hi,
    input logic [LO_W+HI_W-1:0] alarm,
    input logic [PER_W-1:0]     per_cnt,
    input logic [PER_W-1:0]     period,
    input logic [2:0]           irq_stat
);
    // R5
    rtc_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        rtc_clr |=> ({cnt_hi, cnt_lo} == '0));

    // R4
    rtc_lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (frz_lo && !rtc_clr) |=> (cnt_lo == $past(cnt_lo) && cnt_hi == $past(cnt_hi)));

    // R8
    rtc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(irq_stat[2]) |-> (({cnt_hi, cnt_lo} == '0) && $past(&{cnt_hi, cnt_lo})));

    // R6
    rtc_alarm_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(irq_stat[1]) |-> ({cnt_hi, cnt_lo} == $past(alarm)));

    // R9
    pit_fire_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        $rose(irq_stat[0]) |-> ($past(per_cnt) == '0 && $past(tmr_tick) && $past(per_run)));

    // R10
    pit_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        (per_run && per_hold) |=> (per_cnt == $past(per_cnt)));

    // R11
    pit_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
        !per_run |=> (per_cnt == $past(period)));

endmodule

bind tmr_rtc_pit tmr_rtc_pit_chk #(.LO_W(LO_W), .HI_W(HI_W), .PER_W(PER_W)) chk_i (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .tmr_tick (tmr_tick),
    .rtc_clr  (rtc_clr),
    .frz_lo   (frz_lo),
    .per_run  (per_run),
    .per_hold (per_hold),
    .cnt_lo   (cnt_lo),
    .cnt_hi   (cnt_hi),
    .alarm    (alarm),
    .per_cnt  (pit_cnt),
    .period   (regs_q.period),
    .irq_stat (irq_stat)
);

// File: tb/tmr_rtc_pit_tb_top.sv
module tmr_rtc_pit_tb_top;
    localparam int LO_W  = 8;
    localparam int HI_W  = 4;
    localparam int PER_W = 8;
    localparam int LO_M  = (1 << LO_W) - 1;
    localparam int HI_M  = (1 << HI_W) - 1;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        tmr_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_stat;

    always #4 clk = ~clk;

    tmr_rtc_pit #(.LO_W(LO_W), .HI_W(HI_W), .PER_W(PER_W)) dut_i (
        .clk       (clk),
        .rst_ni    (rst_ni),
        .rtc_tick  (rtc_tick),
        .tmr_tick  (tmr_tick),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_stat  (irq_stat)
    );

    typedef struct {
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    // requirement model
    int unsigned m_cnt   = 0;
    int unsigned m_alarm = 0;
    logic [4:0]  m_ctrl  = '0;
    bit m_roll = 0, m_alm = 0, m_per = 0;

    function automatic logic [31:0] exp_stat();
        return {m_roll, m_alm, m_per, 29'd0};
    endfunction

    // monitor: pops the scoreboard on every read
    always @(negedge clk) begin
        exp_t e;
        if (bus_rd) begin
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL unexpected read addr %0d got %h exp none", bus_addr, bus_rdata);
            end else begin
                e = sbq.pop_front();
                if (bus_rdata !== e.exp || bus_addr !== e.addr) begin
                    errors++;
                    $display("FAIL %s addr %0d got %h exp %h", e.tag, e.addr, bus_rdata, e.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(posedge clk); #2;
        bus_rd = 1'b1; bus_addr = a;
        it.addr = a; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(posedge clk); #2;
        bus_rd = 1'b0;
    endtask

    task automatic rd_cnt(input string tag);
        rd(3'd1, 32'(m_cnt & LO_M), tag);
        rd(3'd2, 32'(m_cnt >> LO_W), tag);
    endtask

    task automatic wctrl(input logic [4:0] v);
        wr(3'd0, 32'(v));
        m_ctrl = v;
        if (v[4]) m_cnt = 0;
        if (v == '0) begin m_roll = 0; m_alm = 0; m_per = 0; end
    endtask

    task automatic rtick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2; rtc_tick = 1'b1;
            @(posedge clk); #2; rtc_tick = 1'b0;
            if (m_ctrl[4]) begin
                m_cnt = 0;
            end else if (!m_ctrl[2]) begin
                int unsigned lo, hi;
                lo = m_cnt & LO_M;
                hi = m_cnt >> LO_W;
                if (lo == LO_M && !m_ctrl[3]) begin
                    if (hi == HI_M) m_roll = 1;
                    hi = (hi + 1) & HI_M;
                end
                lo = (lo + 1) & LO_M;
                m_cnt = (hi << LO_W) | lo;
                if (m_cnt == m_alarm) m_alm = 1;
            end
        end
    endtask

    task automatic ptick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2; tmr_tick = 1'b1;
            @(posedge clk); #2; tmr_tick = 1'b0;
        end
    endtask

    task automatic chk_irq(input string tag);
        checks++;
        if (irq_stat !== {m_roll, m_alm, m_per}) begin
            errors++;
            $display("FAIL %s irq_stat got %b exp %b", tag, irq_stat, {m_roll, m_alm, m_per});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got hang exp finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_ni = 1'b1;

        // R1 reset state
        rd(3'd0, 32'd0, "R1 ctrl");
        rd_cnt("R1 count");
        rd(3'd3, 32'd0, "R1 alarm");
        rd(3'd5, 32'd0, "R1 reload");
        rd(3'd6, 32'd0, "R1 status");
        chk_irq("R1");

        // R2 count advance, timer tick has no effect
        rtick(5);
        rd_cnt("R2 five ticks");
        ptick(3);
        rd_cnt("R2 tmr_tick ignored");

        // R3 shadow of high part
        rtick(300);
        rd(3'd1, 32'(m_cnt & LO_M), "R3 low read");
        rd(3'd2, 32'(m_cnt >> LO_W), "R3 high after low");
        begin
            int unsigned hi_snap;
            hi_snap = m_cnt >> LO_W;
            rtick(250);
            rd(3'd2, 32'(hi_snap), "R3 shadow kept across carry");
        end
        rd_cnt("R3 fresh pair");

        // R4 holds
        wctrl(5'b00100);
        rtick(20);
        rd_cnt("R4 low hold stops all");
        wctrl(5'b01000);
        rtick(250);
        rd_cnt("R4 high hold no carry");
        wctrl(5'b00000);

        // R5 clear
        wctrl(5'b10000);
        rtick(3);
        rd_cnt("R5 held at zero");
        wctrl(5'b00000);
        rtick(3);
        rd_cnt("R5 resumes");

        // R6 alarm
        wr(3'd3, 32'd10);
        wr(3'd4, 32'd0);
        m_alarm = 10;
        rtick(6);
        rd(3'd6, exp_stat(), "R6 before match");
        rtick(1);
        rd(3'd6, exp_stat(), "R6 on match");
        chk_irq("R6");

        // R7 write-one-to-clear
        wr(3'd6, 32'h4000_0000);
        m_alm = 0;
        rd(3'd6, exp_stat(), "R7 alarm cleared");

        // R8 rollover of the full count
        wctrl(5'b10000);
        wctrl(5'b00000);
        rtick((1 << (LO_W + HI_W)) - 1);
        rd(3'd6, exp_stat(), "R8 before wrap");
        rtick(1);
        rd(3'd6, exp_stat(), "R8 after wrap");
        rd_cnt("R8 count zero");
        chk_irq("R8");
        wr(3'd6, 32'hE000_0000);
        m_roll = 0; m_alm = 0;
        rd(3'd6, 32'd0, "R7 all cleared");

        // R9 periodic interval reload+1
        wr(3'd5, 32'd3);
        wctrl(5'b00001);
        ptick(3);
        rd(3'd6, exp_stat(), "R9 not yet");
        ptick(1);
        m_per = 1;
        rd(3'd6, exp_stat(), "R9 fires");
        chk_irq("R9");
        wr(3'd6, 32'h2000_0000);
        m_per = 0;
        ptick(3);
        rd(3'd6, exp_stat(), "R9 second period early");
        ptick(1);
        m_per = 1;
        rd(3'd6, exp_stat(), "R9 second period");

        // R10 hold keeps the count
        wr(3'd6, 32'h2000_0000);
        m_per = 0;
        ptick(2);
        wctrl(5'b00011);
        ptick(10);
        rd(3'd6, exp_stat(), "R10 held");
        wctrl(5'b00001);
        ptick(1);
        rd(3'd6, exp_stat(), "R10 resumed one");
        ptick(1);
        m_per = 1;
        rd(3'd6, exp_stat(), "R10 resumed fire");

        // R11 not running
        wr(3'd6, 32'h2000_0000);
        m_per = 0;
        wctrl(5'b01000);
        ptick(10);
        rd(3'd6, exp_stat(), "R11 idle no fire");
        wctrl(5'b00001);
        ptick(3);
        rd(3'd6, exp_stat(), "R11 reload held early");
        ptick(1);
        m_per = 1;
        rd(3'd6, exp_stat(), "R11 reload held fire");

        // R12 zero control write
        wctrl(5'b00000);
        rd(3'd6, 32'd0, "R12 flags cleared");
        rd(3'd0, 32'd0, "R12 ctrl zero");
        chk_irq("R12");
        ptick(10);
        rd(3'd6, 32'd0, "R12 stays idle");

        repeat (3) @(posedge clk);
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL pending reads got %0d exp 0", sbq.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule